// File: doc/BRIEF.md
# Accumulator Execute Stage with Carry Register

This block is the execute stage of a small 8-bit control processor. Each cycle it may accept one instruction, which names a source (one of eight internal registers or the external input port), an optional right rotation and low-bit mask applied to that source, an operation, and a destination (an internal register or the external output port). The operation combines the prepared source with an accumulator register that also lives in the register file. It then writes the result back on the clock edge.

Three operations are decoded: a plain copy, an unsigned add and a bitwise AND. A dedicated carry register holds the carry-out of the most recent add. Only the add instruction updates it, and it can be read as a source but never written as a destination. A combinational read port lets the surrounding pipeline, or a test bench, observe any register.

Top module: `acc_alu_exec`

## Requirements
- R1: Opcode 0 (copy) writes the prepared source value to the destination on the clock edge where `instr_valid` is high.
- R2: Opcode 1 (add) writes the low 8 bits of prepared source plus accumulator (register 0) to the destination.
- R3: Opcode 2 (and) writes the bitwise AND of the prepared source and the accumulator to the destination.
- R4: The source register and the accumulator keep their values after any instruction unless they are that instruction's destination.
- R5: The carry register (register 7) changes only on an edge that executes opcode 1; copy and and instructions leave it unchanged.
- R6: After an add, bits 7 to 1 of the carry register are zero and bit 0 equals the carry out of bit 7 of the adder.
- R7: The carry bit is the unsigned carry-out: 0x7F plus 0x01 gives carry 0, and 0x80 plus 0x80 gives carry 1.
- R8: A write-back addressed to register 7 is dropped. An add so addressed still updates the carry register.
- R9: The source is rotated right by `rot_amt` places (0 to 7). Then only the low `keep_len` bits are kept, with the rest forced to zero; a `keep_len` of 0 keeps all 8 bits.
- R10: With `dst_is_port` high, the result appears on `port_out` and `port_wr` is high for exactly the cycle after the edge; no register except the carry register (on add) changes.
- R11: With `instr_valid` low, or with opcode 3 to 7, no register, `port_out` or `port_wr` state changes (`port_wr` is low).
- R12: Synchronous reset clears all eight registers, `port_out` and `port_wr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction present this cycle |
| opcode | input | 3 | 0 copy, 1 add, 2 and, others no operation |
| src_is_port | input | 1 | Take the source from `port_in` instead of a register |
| src_reg | input | 3 | Source register index |
| rot_amt | input | 3 | Right rotation applied to the source |
| keep_len | input | 3 | Number of low source bits kept, 0 means all |
| dst_is_port | input | 1 | Send the result to `port_out` instead of a register |
| dst_reg | input | 3 | Destination register index |
| port_in | input | 8 | External source data |
| port_out | output | 8 | Registered result for the output port |
| port_wr | output | 1 | One-cycle strobe marking a new `port_out` value |
| rd_addr | input | 3 | Observation read index |
| rd_data | output | 8 | Combinational contents of register `rd_addr` |

## Verification
Every result is due one edge after its instruction. A register write, a carry update and the `port_out`/`port_wr` pair all appear just after the edge that samples the instruction. `rd_data` follows `rd_addr` with no clock at all. The bench drives each instruction at the falling edge and updates its behavioural model at the next rising edge. Half a nanosecond later it sweeps `rd_addr` over all eight registers and compares each against the model, together with the port outputs. The carry, no-effect and port-strobe rules are also held as clocked properties one cycle deep.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   timeunit 1ns; timeprecision 100ps;

   localparam int OPC_W = 3;
   localparam logic [OPC_W-1:0] OPC_COPY = 3'd0;
   localparam logic [OPC_W-1:0] OPC_ADD  = 3'd1;
   localparam logic [OPC_W-1:0] OPC_AND  = 3'd2;

   function automatic logic opc_known(input logic [OPC_W-1:0] op);
      return (op == OPC_COPY) || (op == OPC_ADD) || (op == OPC_AND);
   endfunction
endpackage

// File: rtl/acc_src_prep.sv
module acc_src_prep #(
   parameter int W      = 8,
   parameter bit ROT_EN = 1'b1,
   localparam int SW    = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] rot_amt,
   input  logic [SW-1:0] keep_len,
   output logic [W-1:0]  dout
);
   timeunit 1ns; timeprecision 100ps;

   logic [W-1:0] rot_v;

   generate
      if (ROT_EN) begin : g_rot
         always_comb begin
            for (int i = 0; i < W; i++) begin
               rot_v[i] = din[(i + int'(rot_amt)) % W];
            end
         end
      end else begin : g_norot
         assign rot_v = din;
      end
   endgenerate

   for (genvar i = 0; i < W; i++) begin : g_mask
      assign dout[i] = rot_v[i] & ((keep_len == '0) || (SW'(i) < keep_len));
   end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [OPC_W-1:0] opcode,
   input  logic [W-1:0]     opnd,
   input  logic [W-1:0]     acc,
   output logic [W-1:0]     result,
   output logic             cout
);
   timeunit 1ns; timeprecision 100ps;

   logic [W:0] sum;

   assign sum  = {1'b0, opnd} + {1'b0, acc};
   assign cout = sum[W];

   always_comb begin
      unique case (opcode)
         OPC_ADD: result = sum[W-1:0];
         OPC_AND: result = opnd & acc;
         default: result = opnd;
      endcase
   end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
   parameter int W       = 8,
   parameter int N       = 8,
   parameter int ACC_IDX = 0,
   parameter int CY_IDX  = 7,
   localparam int AW     = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          cy_we,
   input  logic          cy_bit,
   input  logic [AW-1:0] ra1,
   output logic [W-1:0]  rd1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd2,
   output logic [W-1:0]  acc_q,
   output logic [W-1:0]  cy_q
);
   timeunit 1ns; timeprecision 100ps;

   logic [W-1:0] regs [N];

   for (genvar i = 0; i < N; i++) begin : g_reg
      if (i == CY_IDX) begin : g_cy
         always_ff @(posedge clk) begin
            if (rst)        regs[i] <= '0;
            else if (cy_we) regs[i] <= W'(cy_bit);
         end
      end else begin : g_gp
         always_ff @(posedge clk) begin
            if (rst)                           regs[i] <= '0;
            else if (we && waddr == AW'(i))    regs[i] <= wdata;
         end
      end
   end

   assign rd1   = regs[ra1];
   assign rd2   = regs[ra2];
   assign acc_q = regs[ACC_IDX];
   assign cy_q  = regs[CY_IDX];
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
   import acc_alu_pkg::*;
#(
   parameter int  W       = 8,
   parameter int  N       = 8,
   parameter int  ACC_IDX = 0,
   parameter int  CY_IDX  = 7,
   parameter bit  ROT_EN  = 1'b1,
   localparam int AW      = $clog2(N),
   localparam int SW      = $clog2(W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             instr_valid,
   input  logic [OPC_W-1:0] opcode,
   input  logic             src_is_port,
   input  logic [AW-1:0]    src_reg,
   input  logic [SW-1:0]    rot_amt,
   input  logic [SW-1:0]    keep_len,
   input  logic             dst_is_port,
   input  logic [AW-1:0]    dst_reg,
   input  logic [W-1:0]     port_in,
   output logic [W-1:0]     port_out,
   output logic             port_wr,
   input  logic [AW-1:0]    rd_addr,
   output logic [W-1:0]     rd_data
);
   timeunit 1ns; timeprecision 100ps;

   if (W < 2 || (1 << SW) != W) begin : g_bad_w
      $error("acc_alu_exec: W must be a power of two of at least 2");
   end
   if (N < 2 || (1 << AW) != N) begin : g_bad_n
      $error("acc_alu_exec: N must be a power of two of at least 2");
   end
   if (ACC_IDX == CY_IDX || ACC_IDX >= N || CY_IDX >= N) begin : g_bad_idx
      $error("acc_alu_exec: accumulator and carry indices must differ and fit N");
   end

   logic [W-1:0] src_reg_val, src_raw, src_prep, acc_q, cy_q, result;
   logic         cout, fire, reg_we, cy_we;

   assign fire   = instr_valid && opc_known(opcode);
   assign reg_we = fire && !dst_is_port;
   assign cy_we  = instr_valid && (opcode == OPC_ADD);

   assign src_raw = src_is_port ? port_in : src_reg_val;

   acc_src_prep #(.W(W), .ROT_EN(ROT_EN)) u_prep (
      .din      (src_raw),
      .rot_amt  (rot_amt),
      .keep_len (keep_len),
      .dout     (src_prep)
   );

   acc_alu_core #(.W(W)) u_core (
      .opcode (opcode),
      .opnd   (src_prep),
      .acc    (acc_q),
      .result (result),
      .cout   (cout)
   );

   acc_regfile #(.W(W), .N(N), .ACC_IDX(ACC_IDX), .CY_IDX(CY_IDX)) u_rf (
      .clk    (clk),
      .rst    (rst),
      .we     (reg_we),
      .waddr  (dst_reg),
      .wdata  (result),
      .cy_we  (cy_we),
      .cy_bit (cout),
      .ra1    (src_reg),
      .rd1    (src_reg_val),
      .ra2    (rd_addr),
      .rd2    (rd_data),
      .acc_q  (acc_q),
      .cy_q   (cy_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         port_out <= '0;
         port_wr  <= 1'b0;
      end else begin
         port_wr <= fire && dst_is_port;
         if (fire && dst_is_port) port_out <= result;
      end
   end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int W      = 8,
   parameter int AW     = 3,
   parameter int CY_IDX = 7
) (
   input logic          clk,
   input logic          rst,
   input logic          instr_valid,
   input logic [2:0]    opcode,
   input logic          src_is_port,
   input logic [2:0]    rot_amt,
   input logic [2:0]    keep_len,
   input logic          dst_is_port,
   input logic [AW-1:0] dst_reg,
   input logic [W-1:0]  port_in,
   input logic          port_wr,
   input logic [W-1:0]  acc_q,
   input logic [W-1:0]  cy_q
);
   timeunit 1ns; timeprecision 100ps;

   p_carry_only_add_r5: assert property (@(posedge clk) disable iff (rst)
      !(instr_valid && opcode == 3'd1) |=> $stable(cy_q));

   p_carry_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && opcode == 3'd1) |=> (cy_q[W-1:1] == '0));

   p_unsigned_carry_r7: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && opcode == 3'd1 && src_is_port && rot_amt == 3'd0 && keep_len == 3'd0)
      |=> (cy_q[0] == (({1'b0, $past(acc_q)} + {1'b0, $past(port_in)}) >> W)));

   p_carry_not_dest_r8: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && !dst_is_port && dst_reg == AW'(CY_IDX) && opcode != 3'd1)
      |=> $stable(cy_q));

   p_port_dest_keeps_acc_r10: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && dst_is_port) |=> $stable(acc_q));

   p_port_strobe_r10: assert property (@(posedge clk) disable iff (rst)
      port_wr |-> $past(instr_valid && dst_is_port && opcode <= 3'd2));

   p_idle_no_change_r11: assert property (@(posedge clk) disable iff (rst)
      (!instr_valid || opcode > 3'd2) |=> ($stable(acc_q) && $stable(cy_q) && !port_wr));

   p_reset_clears_r12: assert property (@(posedge clk)
      rst |=> (acc_q == '0 && cy_q == '0 && !port_wr));
endmodule

bind acc_alu_exec acc_alu_chk #(.W(W), .AW(AW), .CY_IDX(CY_IDX)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .instr_valid (instr_valid),
   .opcode      (opcode),
   .src_is_port (src_is_port),
   .rot_amt     (rot_amt),
   .keep_len    (keep_len),
   .dst_is_port (dst_is_port),
   .dst_reg     (dst_reg),
   .port_in     (port_in),
   .port_wr     (port_wr),
   .acc_q       (acc_q),
   .cy_q        (cy_q)
);

// File: tb/sim_acc_alu_exec.sv
module sim_acc_alu_exec;
   timeunit 1ns; timeprecision 100ps;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       instr_valid = 1'b0;
   logic [2:0] opcode = '0;
   logic       src_is_port = 1'b0;
   logic [2:0] src_reg = '0;
   logic [2:0] rot_amt = '0;
   logic [2:0] keep_len = '0;
   logic       dst_is_port = 1'b0;
   logic [2:0] dst_reg = '0;
   logic [7:0] port_in = '0;
   logic [7:0] port_out;
   logic       port_wr;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] m_reg [8];
   logic [7:0] m_port = '0;
   logic       m_wr   = 1'b0;

   always #4 clk = ~clk;

   acc_alu_exec u0 (
      .clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode),
      .src_is_port(src_is_port), .src_reg(src_reg), .rot_amt(rot_amt),
      .keep_len(keep_len), .dst_is_port(dst_is_port), .dst_reg(dst_reg),
      .port_in(port_in), .port_out(port_out), .port_wr(port_wr),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] prep(input logic [7:0] s, input int r, input int l);
      logic [15:0] t;
      logic [7:0]  v;
      t = {s, s} >> r;
      v = t[7:0];
      if (l != 0) v = v & 8'((16'd1 << l) - 16'd1);
      return v;
   endfunction

   task automatic compare_all(input string req);
      for (int k = 0; k < 8; k++) begin
         rd_addr = 3'(k);
         #0.2;
         chk(req, $sformatf("reg%0d", k), rd_data, m_reg[k]);
      end
      chk(req, "port_wr", {7'b0, port_wr}, {7'b0, m_wr});
      chk(req, "port_out", port_out, m_port);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      instr_valid = 1'b0;
      @(posedge clk);
      @(posedge clk);
      for (int k = 0; k < 8; k++) m_reg[k] = '0;
      m_port = '0;
      m_wr   = 1'b0;
      #0.5;
      compare_all("R12");
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic step(input string req, input bit v, input int op, input bit sp, input int sr,
                       input int ra, input int kl, input bit dp, input int dr, input logic [7:0] pin);
      logic [7:0] src, res;
      logic [8:0] sum;
      @(negedge clk);
      instr_valid = v; opcode = 3'(op); src_is_port = sp; src_reg = 3'(sr);
      rot_amt = 3'(ra); keep_len = 3'(kl); dst_is_port = dp; dst_reg = 3'(dr); port_in = pin;
      @(posedge clk);
      src = prep(sp ? pin : m_reg[sr], ra, kl);
      sum = {1'b0, src} + {1'b0, m_reg[0]};
      res = (op == 1) ? sum[7:0] : (op == 2) ? (src & m_reg[0]) : src;
      m_wr = 1'b0;
      if (v && op <= 2) begin
         if (dp) begin
            m_port = res;
            m_wr   = 1'b1;
         end else if (dr != 7) begin
            m_reg[dr] = res;
         end
      end
      if (v && op == 1) m_reg[7] = {7'b0, sum[8]};
      #0.5;
      compare_all(req);
   endtask

   initial begin
      for (int k = 0; k < 8; k++) m_reg[k] = '0;
      do_reset();
      // R1: load registers 0..6 from the port
      for (int k = 0; k < 7; k++) step("R1", 1, 0, 1, 0, 0, 0, 0, k, 8'(8'h11 * (k + 1)));
      // R8: copy into the carry register is dropped
      step("R8", 1, 0, 1, 0, 0, 0, 0, 7, 8'hAA);
      // R4: register to register copy leaves the source alone
      step("R4", 1, 0, 0, 3, 0, 0, 0, 5, 8'h00);
      // R7: 0x7F + 0x01 gives carry 0
      step("R7", 1, 0, 1, 0, 0, 0, 0, 0, 8'h7F);
      step("R7", 1, 1, 1, 0, 0, 0, 0, 2, 8'h01);
      // R6: 0x80 + 0x80 gives carry 1, sum 0
      step("R6", 1, 0, 1, 0, 0, 0, 0, 0, 8'h80);
      step("R6", 1, 1, 1, 0, 0, 0, 0, 4, 8'h80);
      // R5: copy and and keep the carry at 1
      step("R5", 1, 2, 0, 6, 0, 0, 0, 1, 8'h00);
      step("R5", 1, 0, 0, 2, 0, 0, 0, 3, 8'h00);
      // R8: add aimed at the carry register still clears the carry
      step("R8", 1, 1, 1, 0, 0, 0, 0, 7, 8'h01);
      // R2: add into the accumulator itself
      step("R2", 1, 1, 0, 6, 0, 0, 0, 0, 8'h00);
      // R3: and with the accumulator
      step("R3", 1, 2, 1, 0, 0, 0, 0, 1, 8'h3C);
      // R9: rotate and mask
      step("R9", 1, 0, 1, 0, 1, 0, 0, 2, 8'h81);
      step("R9", 1, 0, 1, 0, 4, 4, 0, 3, 8'hA5);
      step("R9", 1, 0, 1, 0, 7, 1, 0, 4, 8'h40);
      step("R9", 1, 0, 0, 6, 3, 0, 0, 5, 8'h00);
      // R10: port destination and one-cycle strobe
      step("R10", 1, 1, 1, 0, 0, 0, 1, 0, 8'h0F);
      step("R10", 0, 0, 0, 0, 0, 0, 1, 0, 8'h00);
      step("R10", 1, 2, 0, 4, 0, 0, 1, 0, 8'h00);
      // R11: no effect when idle or for opcodes 3..7
      step("R11", 1, 5, 1, 0, 0, 0, 0, 0, 8'hFF);
      step("R11", 1, 3, 1, 0, 0, 0, 1, 7, 8'hFF);
      step("R11", 0, 1, 1, 0, 0, 0, 0, 0, 8'hFF);
      // mixed traffic
      for (int n = 0; n < 400; n++) begin
         int op;
         string tag;
         op  = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 3);
         tag = (op == 0) ? "R1" : (op == 1) ? "R2" : (op == 2) ? "R3" : "R11";
         step(tag, ($urandom % 8) != 0, op, $urandom % 2, $urandom % 8, $urandom % 8,
              ($urandom % 2) ? 0 : int'($urandom % 8), ($urandom % 5) == 0, $urandom % 8, 8'($urandom));
      end
      do_reset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule